// File: doc/BRIEF.md
# Program Fetch Address Unit

This block produces the code-memory addresses for a small 8-bit controller core. It holds a 16-bit program counter and a 16-bit data pointer. Each fetch request puts the current program counter on the code address output and advances the counter by one. A load port lets the branch logic replace the counter, for example on a jump. The data pointer is a pair of byte registers. Each byte can be written on its own, or both can be written together as one 16-bit word. The pointer's value is always visible for external data accesses, and it can also be put on the code address output for a table read from code space.

Every code access is routed to one of two targets. Addresses below a fixed on-chip limit, which defaults to 4 KB, go to the on-chip code ROM. Addresses at or above the limit go to the external bus. An active-low external-access input, sampled every cycle, sends every code access to the external bus while it is held low. When no access is requested, both select outputs stay low.

Top module: `pfa_fetch_unit`

## Requirements
- R1: While synchronous active-high reset `rst` is applied, and on the first cycle after it is released, `pc_out` and `dp_out` are both 0x0000.
- R2: When `fetch_req` is high and neither `pc_load` nor `dp_code_rd` is high, `code_addr` shows the current program counter in that cycle, and `pc_out` is one greater after the next rising edge.
- R3: When `pc_load` is high, `pc_out` takes `pc_load_val` at the next edge. This holds even if `fetch_req` is high in the same cycle: the load wins and no increment is applied.
- R4: An increment from 0xFFFF gives 0x0000.
- R5: With `ext_access_n` high, an access to an address from 0x0000 to 0x0FFF raises `rom_sel` and keeps `ext_sel` low.
- R6: With `ext_access_n` high, an access to an address of 0x1000 or above raises `ext_sel` and keeps `rom_sel` low.
- R7: While `ext_access_n` is low, every access raises `ext_sel` and never `rom_sel`, whatever the address.
- R8: `dp_wr_lo` loads `dp_byte` into bits 7:0 of the data pointer, and `dp_wr_hi` loads it into bits 15:8. The other byte keeps its value.
- R9: `dp_wr_word` loads all 16 bits from `dp_word`. If a byte write arrives in the same cycle, the word write overrides it.
- R10: When `dp_code_rd` is high, `code_addr` equals the data pointer and is steered by the same address rules as a fetch. `pc_out` does not change in that cycle, even if `fetch_req` is also high.
- R11: When neither `fetch_req` nor `dp_code_rd` is high, `rom_sel` and `ext_sel` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | Fetch one instruction byte at the program counter |
| pc_load | input | 1 | Replace the program counter |
| pc_load_val | input | 16 | New program counter value |
| dp_wr_lo | input | 1 | Write the data pointer low byte |
| dp_wr_hi | input | 1 | Write the data pointer high byte |
| dp_wr_word | input | 1 | Write the whole data pointer |
| dp_byte | input | 8 | Byte write data |
| dp_word | input | 16 | Word write data |
| dp_code_rd | input | 1 | Code-space read at the data pointer |
| ext_access_n | input | 1 | Low: all code accesses external |
| code_addr | output | 16 | Address of the current code access |
| rom_sel | output | 1 | Access goes to the on-chip ROM |
| ext_sel | output | 1 | Access goes to the external bus |
| pc_out | output | 16 | Program counter |
| dp_out | output | 16 | Data pointer |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 4096-byte on-chip region. This places the ROM-to-external boundary between 0x0FFF and 0x1000, where a short directed sequence can cross it with consecutive fetches. With 16 bits, the wrap from 0xFFFF to 0x0000 is reached in a single load followed by one fetch. The byte registers are 8 bits wide, so separate high and low writes assemble a known word, and the bench can check that each write left the other byte unchanged.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    typedef enum logic [1:0] {
        ROUTE_IDLE   = 2'd0,
        ROUTE_ONCHIP = 2'd1,
        ROUTE_EXTERN = 2'd2
    } route_e;

    typedef struct packed {
        logic word;
        logic hi;
        logic lo;
    } dp_wr_t;

    // Choose the target of a code access.
    function automatic route_e pick_route(input logic active,
                                          input logic force_ext,
                                          input logic below_limit);
        if (!active)
            return ROUTE_IDLE;
        else if (!force_ext && below_limit)
            return ROUTE_ONCHIP;
        else
            return ROUTE_EXTERN;
    endfunction

endpackage

// File: rtl/pfa_prog_counter.sv
module pfa_prog_counter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load)
            pc_q <= load_val;
        else if (inc)
            pc_q <= pc_q + STEP;   // natural wrap at the top
    end

    assign pc = pc_q;
endmodule

// File: rtl/pfa_data_pointer.sv
module pfa_data_pointer #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pfa_pkg::dp_wr_t   wr,
    input  logic [ADDR_W/2-1:0] byte_in,
    input  logic [ADDR_W-1:0] word_in,
    output logic [ADDR_W-1:0] dp
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam int NPARTS = 2;

    logic [NPARTS-1:0] byte_we;
    assign byte_we = {wr.hi, wr.lo};

    for (genvar g = 0; g < NPARTS; g++) begin : g_part
        logic [BYTE_W-1:0] part_q;
        always_ff @(posedge clk) begin
            if (rst)
                part_q <= '0;
            else if (wr.word)
                part_q <= word_in[g*BYTE_W +: BYTE_W];
            else if (byte_we[g])
                part_q <= byte_in;
        end
        assign dp[g*BYTE_W +: BYTE_W] = part_q;
    end
endmodule

// File: rtl/pfa_fetch_steer.sv
module pfa_fetch_steer #(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_BYTES = 4096
) (
    input  logic              active,
    input  logic              ext_access_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rom_sel,
    output logic              ext_sel
);
    import pfa_pkg::*;

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ONCHIP_BYTES);

    logic   below;
    route_e route;

    if (ONCHIP_BYTES == 0) begin : g_no_rom
        assign below = 1'b0;
    end else begin : g_rom
        assign below = {1'b0, addr} < LIMIT;
    end

    assign route   = pick_route(active, ~ext_access_n, below);
    assign rom_sel = (route == ROUTE_ONCHIP);
    assign ext_sel = (route == ROUTE_EXTERN);
endmodule

// File: rtl/pfa_fetch_unit.sv
module pfa_fetch_unit #(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fetch_req,
    input  logic                pc_load,
    input  logic [ADDR_W-1:0]   pc_load_val,
    input  logic                dp_wr_lo,
    input  logic                dp_wr_hi,
    input  logic                dp_wr_word,
    input  logic [ADDR_W/2-1:0] dp_byte,
    input  logic [ADDR_W-1:0]   dp_word,
    input  logic                dp_code_rd,
    input  logic                ext_access_n,
    output logic [ADDR_W-1:0]   code_addr,
    output logic                rom_sel,
    output logic                ext_sel,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [ADDR_W-1:0]   dp_out
);
    import pfa_pkg::*;

    dp_wr_t dp_wr;
    logic   access;
    logic   pc_inc;

    assign dp_wr  = '{word: dp_wr_word, hi: dp_wr_hi, lo: dp_wr_lo};
    assign access = fetch_req | dp_code_rd;
    assign pc_inc = fetch_req & ~dp_code_rd;

    pfa_prog_counter #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_load),
        .load_val (pc_load_val),
        .inc      (pc_inc),
        .pc       (pc_out)
    );

    pfa_data_pointer #(.ADDR_W(ADDR_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .wr      (dp_wr),
        .byte_in (dp_byte),
        .word_in (dp_word),
        .dp      (dp_out)
    );

    assign code_addr = dp_code_rd ? dp_out : pc_out;

    pfa_fetch_steer #(.ADDR_W(ADDR_W), .ONCHIP_BYTES(ONCHIP_BYTES)) u_steer (
        .active       (access),
        .ext_access_n (ext_access_n),
        .addr         (code_addr),
        .rom_sel      (rom_sel),
        .ext_sel      (ext_sel)
    );
endmodule

// File: rtl/pfa_fetch_checker.sv
module pfa_fetch_checker #(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_BYTES = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              pc_load,
    input logic [ADDR_W-1:0] pc_load_val,
    input logic              dp_wr_word,
    input logic [ADDR_W-1:0] dp_word,
    input logic              dp_code_rd,
    input logic              ext_access_n,
    input logic [ADDR_W-1:0] code_addr,
    input logic              rom_sel,
    input logic              ext_sel,
    input logic [ADDR_W-1:0] pc_out,
    input logic [ADDR_W-1:0] dp_out
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ONCHIP_BYTES);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && dp_out == '0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !pc_load && !dp_code_rd) |=> (pc_out == ADDR_W'($past(pc_out) + 1'b1)));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (pc_out == $past(pc_load_val)));

    assert_rom_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> ({1'b0, code_addr} < LIMIT));

    assert_force_external_R7: assert property (@(posedge clk) disable iff (rst)
        !ext_access_n |-> !rom_sel);

    assert_word_write_R9: assert property (@(posedge clk) disable iff (rst)
        dp_wr_word |=> (dp_out == $past(dp_word)));

    assert_table_read_R10: assert property (@(posedge clk) disable iff (rst)
        dp_code_rd |-> (code_addr == dp_out));

    assert_pc_held_R10: assert property (@(posedge clk) disable iff (rst)
        (dp_code_rd && !pc_load) |=> $stable(pc_out));

    assert_one_target_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ext_sel}));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && !dp_code_rd) |-> (!rom_sel && !ext_sel));
endmodule

bind pfa_fetch_unit pfa_fetch_checker #(
    .ADDR_W(ADDR_W), .ONCHIP_BYTES(ONCHIP_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_req    (fetch_req),
    .pc_load      (pc_load),
    .pc_load_val  (pc_load_val),
    .dp_wr_word   (dp_wr_word),
    .dp_word      (dp_word),
    .dp_code_rd   (dp_code_rd),
    .ext_access_n (ext_access_n),
    .code_addr    (code_addr),
    .rom_sel      (rom_sel),
    .ext_sel      (ext_sel),
    .pc_out       (pc_out),
    .dp_out       (dp_out)
);

// File: tb/tb_pfa_fetch_unit.sv
module tb_pfa_fetch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_load_val = '0;
    logic        dp_wr_lo = 1'b0;
    logic        dp_wr_hi = 1'b0;
    logic        dp_wr_word = 1'b0;
    logic [7:0]  dp_byte = '0;
    logic [15:0] dp_word = '0;
    logic        dp_code_rd = 1'b0;
    logic        ext_access_n = 1'b1;
    logic [15:0] code_addr;
    logic        rom_sel;
    logic        ext_sel;
    logic [15:0] pc_out;
    logic [15:0] dp_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pfa_fetch_unit dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .pc_load(pc_load),
        .pc_load_val(pc_load_val), .dp_wr_lo(dp_wr_lo), .dp_wr_hi(dp_wr_hi),
        .dp_wr_word(dp_wr_word), .dp_byte(dp_byte), .dp_word(dp_word),
        .dp_code_rd(dp_code_rd), .ext_access_n(ext_access_n),
        .code_addr(code_addr), .rom_sel(rom_sel), .ext_sel(ext_sel),
        .pc_out(pc_out), .dp_out(dp_out)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        fetch;
        logic        load;
        logic [15:0] lval;
        logic        wlo;
        logic        whi;
        logic        wword;
        logic [7:0]  bval;
        logic [15:0] wval;
        logic        dprd;
        logic        extn;
        logic [15:0] e_addr;
        logic        e_rom;
        logic        e_ext;
        logic [15:0] e_pc;
        logic [15:0] e_dp;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        //  tag    f  ld lval      wl wh ww bval   wval     rd en addr     rom ext pc       dp
        '{"R5 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0000, 1, 0, 16'h0001, 16'h0000},
        '{"R2 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0001, 1, 0, 16'h0002, 16'h0000},
        '{"R3 ", 1, 1, 16'h0FFF, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0002, 1, 0, 16'h0FFF, 16'h0000},
        '{"R5 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0FFF, 1, 0, 16'h1000, 16'h0000},
        '{"R6 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h1000, 0, 1, 16'h1001, 16'h0000},
        '{"R8 ", 0, 0, 16'h0000, 1, 0, 0, 8'h34, 16'h0000, 0, 1, 16'h1001, 0, 0, 16'h1001, 16'h0034},
        '{"R8 ", 0, 0, 16'h0000, 0, 1, 0, 8'h12, 16'h0000, 0, 1, 16'h1001, 0, 0, 16'h1001, 16'h1234},
        '{"R10", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 1, 1, 16'h1234, 0, 1, 16'h1001, 16'h1234},
        '{"R9 ", 0, 0, 16'h0000, 0, 0, 1, 8'h00, 16'h0ABC, 0, 1, 16'h1001, 0, 0, 16'h1001, 16'h0ABC},
        '{"R10", 0, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 1, 1, 16'h0ABC, 1, 0, 16'h1001, 16'h0ABC},
        '{"R11", 0, 1, 16'h0010, 0, 0, 0, 8'h00, 16'h0000, 0, 0, 16'h1001, 0, 0, 16'h0010, 16'h0ABC},
        '{"R7 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 0, 16'h0010, 0, 1, 16'h0011, 16'h0ABC},
        '{"R9 ", 0, 0, 16'h0000, 1, 1, 1, 8'hEE, 16'h5555, 0, 1, 16'h0011, 0, 0, 16'h0011, 16'h5555},
        '{"R3 ", 0, 1, 16'hFFFF, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0011, 0, 0, 16'hFFFF, 16'h5555},
        '{"R4 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'hFFFF, 0, 1, 16'h0000, 16'h5555},
        '{"R2 ", 1, 0, 16'h0000, 0, 0, 0, 8'h00, 16'h0000, 0, 1, 16'h0000, 1, 0, 16'h0001, 16'h5555}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_req = 1'b0; pc_load = 1'b0; pc_load_val = '0;
        dp_wr_lo = 1'b0; dp_wr_hi = 1'b0; dp_wr_word = 1'b0;
        dp_byte = '0; dp_word = '0; dp_code_rd = 1'b0; ext_access_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "pc_out in reset", pc_out, 16'h0000);
        check("R1", "dp_out in reset", dp_out, 16'h0000);
        check("R11", "rom_sel idle", {15'd0, rom_sel}, 16'd0);
        check("R11", "ext_sel idle", {15'd0, ext_sel}, 16'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1", "pc_out after release", pc_out, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            fetch_req   = VECS[i].fetch;
            pc_load     = VECS[i].load;
            pc_load_val = VECS[i].lval;
            dp_wr_lo    = VECS[i].wlo;
            dp_wr_hi    = VECS[i].whi;
            dp_wr_word  = VECS[i].wword;
            dp_byte     = VECS[i].bval;
            dp_word     = VECS[i].wval;
            dp_code_rd  = VECS[i].dprd;
            ext_access_n = VECS[i].extn;
            #1;
            check($sformatf("%s", VECS[i].tag), $sformatf("vec %0d code_addr", i),
                  code_addr, VECS[i].e_addr);
            check($sformatf("%s", VECS[i].tag), $sformatf("vec %0d rom_sel", i),
                  {15'd0, rom_sel}, {15'd0, VECS[i].e_rom});
            check($sformatf("%s", VECS[i].tag), $sformatf("vec %0d ext_sel", i),
                  {15'd0, ext_sel}, {15'd0, VECS[i].e_ext});
            @(posedge clk); #1;
            check($sformatf("%s", VECS[i].tag), $sformatf("vec %0d pc_out", i),
                  pc_out, VECS[i].e_pc);
            check($sformatf("%s", VECS[i].tag), $sformatf("vec %0d dp_out", i),
                  dp_out, VECS[i].e_dp);
        end

        // R7: forced external at the very bottom of code space
        @(negedge clk);
        idle_inputs();
        pc_load = 1'b1; pc_load_val = 16'h0000;
        @(negedge clk);
        idle_inputs();
        fetch_req = 1'b1; ext_access_n = 1'b0;
        #1;
        check("R7", "rom_sel at 0x0000 forced", {15'd0, rom_sel}, 16'd0);
        check("R7", "ext_sel at 0x0000 forced", {15'd0, ext_sel}, 16'd1);

        // R1: reset in mid-run clears both registers
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", "pc_out after mid-run reset", pc_out, 16'h0000);
        check("R1", "dp_out after mid-run reset", dp_out, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;

        finish_run();
    end
endmodule